// File: doc/BRIEF.md
# Segmented Best-Fit Heap Allocator

This block serves memory allocation and release requests issued by one hardware thread against its private local memory. The upper end of the local address range is divided at build time into three pools of fixed segments (8, 32 and 1024 bytes by default). Each pool keeps one busy bit per segment. A request is served from the smallest class that can hold it. If that class has no free segment, the next larger class is tried. Because all segments have fixed positions, the heap never fragments and never needs compaction.

A request larger than the biggest segment is handled differently. It is carved from the space below the pools by moving a heap pointer downward. Only one such block can be live at a time, and releasing it restores the pointer. Every request is one cycle wide and receives a response one cycle later. The response carries the allocated address, or zero when the request cannot be met, and an error flag for a bad release.

Top module: `seg_heap_alloc`

## Requirements
- R1: After reset every segment is free, no oversized block is live, and `rsp_valid` is low.
- R2: An allocation (`req_op`=0) of 0 to 8 bytes returns the lowest-addressed free 8-byte segment. The 8-byte pool starts at HEAP_TOP − (BIG_SEGS·1024 + MID_SEGS·32 + SMALL_SEGS·8) and its segments are 8 bytes apart.
- R3: An allocation of 9 to 32 bytes is served from the 32-byte pool, which sits directly above the 8-byte pool. An allocation of 33 to 1024 bytes is served from the 1024-byte pool, which sits directly above the 32-byte pool and ends at HEAP_TOP.
- R4: When the smallest fitting class is full, the allocation is served from the next larger class that has a free segment.
- R5: An allocation of at most 1024 bytes returns address 0 when no fitting class has a free segment.
- R6: An allocation larger than 1024 bytes, made while no oversized block is live, returns heap pointer − size and lowers the heap pointer to that address. The heap pointer starts at the base of the 8-byte pool.
- R7: A second allocation larger than 1024 bytes, made while an oversized block is live, returns 0.
- R8: An oversized allocation whose result would fall below HEAP_FLOOR returns 0. A result exactly equal to HEAP_FLOOR is granted.
- R9: A release (`req_op`=1) of a currently allocated segment address frees it, so that segment can be allocated again.
- R10: Releasing the live oversized block restores the heap pointer to its value before that allocation.
- R11: A release of any address that is not a live allocation leaves all state unchanged and sets `rsp_err`. Examples are a misaligned address, an address outside the heap, and an address that is already free.
- R12: Every request produces exactly one response cycle with `rsp_valid` high, one cycle after the request. Allocation responses have `rsp_err`=0. Release responses have `rsp_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_size | input | ADDR_W | Bytes requested (allocate) |
| req_addr | input | ADDR_W | Address to release (release) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_addr | output | ADDR_W | Allocated address, or 0 |
| rsp_err | output | 1 | Release did not match a live allocation |

## Verification
The bench builds the allocator with HEAP_TOP=8192 and HEAP_FLOOR=2048, using two 8-byte segments, two 32-byte segments and one 1024-byte segment. With pools this small, a handful of requests exhausts every class. That brings the fallback order, the all-full null result and re-use after release within reach.

The small top and floor also place the heap-pointer limit at a reachable size of 5040 bytes. The bench tests both sides of that limit, the single-oversized-block rule, and pointer restoration.

// File: rtl/seg_heap_pkg.sv
package seg_heap_pkg;
    typedef enum logic {
        OP_MALLOC = 1'b0,
        OP_FREE   = 1'b1
    } heap_op_e;

    localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/seg_heap_pool.sv
module seg_heap_pool #(
    parameter int ADDR_W    = 16,
    parameter int SEG_BYTES = 8,
    parameter int COUNT     = 8,
    parameter int BASE      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              rel,
    input  logic [ADDR_W-1:0] rel_addr,
    output logic              has_free,
    output logic [ADDR_W-1:0] pick_addr,
    output logic              rel_hit
);
    localparam int SHIFT = $clog2(SEG_BYTES);
    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam int SPAN  = SEG_BYTES * COUNT;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(SEG_BYTES - 1);

    typedef struct packed {
        logic [COUNT-1:0] busy;
    } pool_t;

    pool_t s_d, s_q;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  rel_idx;
    logic [ADDR_W-1:0] offset;
    logic              in_range;

    always_comb begin
        // lowest free index wins
        pick_idx = '0;
        has_free = 1'b0;
        for (int i = COUNT - 1; i >= 0; i--) begin
            if (!s_q.busy[i]) begin
                pick_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
        pick_addr = BASE_A + (ADDR_W'(pick_idx) << SHIFT);

        offset   = rel_addr - BASE_A;
        in_range = (rel_addr >= BASE_A) && ({16'd0, offset} < 32'(SPAN));
        rel_idx  = IDX_W'(offset >> SHIFT);
        rel_hit  = in_range && ((offset & MASK_A) == '0) && s_q.busy[rel_idx];

        s_d = s_q;
        if (take) s_d.busy[pick_idx] = 1'b1;
        if (rel && rel_hit) s_d.busy[rel_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_take_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> has_free);

    assert_take_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> $countones(s_q.busy) == $past($countones(s_q.busy)) + 1);

    assert_rel_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && rel_hit) |=> $countones(s_q.busy) + 1 == $past($countones(s_q.busy)));

endmodule

// File: rtl/seg_heap_alloc.sv
module seg_heap_alloc
    import seg_heap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SMALL_BYTES = 8,
    parameter int MID_BYTES   = 32,
    parameter int BIG_BYTES   = 1024,
    parameter int SMALL_SEGS  = 8,
    parameter int MID_SEGS    = 8,
    parameter int BIG_SEGS    = 4,
    parameter int HEAP_TOP    = 32768,
    parameter int HEAP_FLOOR  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);
    function automatic int cls_bytes(input int c);
        case (c)
            0:       return SMALL_BYTES;
            1:       return MID_BYTES;
            default: return BIG_BYTES;
        endcase
    endfunction

    function automatic int cls_count(input int c);
        case (c)
            0:       return SMALL_SEGS;
            1:       return MID_SEGS;
            default: return BIG_SEGS;
        endcase
    endfunction

    // pools stacked downward from the top: big, then mid, then small
    function automatic int cls_base(input int c);
        int b;
        b = HEAP_TOP;
        for (int k = NUM_CLASSES - 1; k >= c; k--) b = b - cls_bytes(k) * cls_count(k);
        return b;
    endfunction

    localparam logic [ADDR_W-1:0] HP_RESET = ADDR_W'(cls_base(0));
    localparam logic [ADDR_W-1:0] FLOOR_A  = ADDR_W'(HEAP_FLOOR);
    localparam logic [ADDR_W-1:0] BIG_A    = ADDR_W'(BIG_BYTES);

    typedef struct packed {
        logic              rsp_valid;
        logic [ADDR_W-1:0] rsp_addr;
        logic              rsp_err;
        logic              big_busy;
        logic [ADDR_W-1:0] big_addr;
        logic [ADDR_W-1:0] hp;
        logic [ADDR_W-1:0] hp_saved;
    } alloc_t;

    alloc_t s_d, s_q;

    logic [NUM_CLASSES-1:0] take, rel, has_free, rel_hit, fits;
    logic [ADDR_W-1:0]      pick_addr [NUM_CLASSES];

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        seg_heap_pool #(
            .ADDR_W    (ADDR_W),
            .SEG_BYTES (cls_bytes(c)),
            .COUNT     (cls_count(c)),
            .BASE      (cls_base(c))
        ) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (take[c]),
            .rel       (rel[c]),
            .rel_addr  (req_addr),
            .has_free  (has_free[c]),
            .pick_addr (pick_addr[c]),
            .rel_hit   (rel_hit[c])
        );
        assign fits[c] = (req_size <= ADDR_W'(cls_bytes(c)));
    end

    logic              is_malloc, is_free, found;
    logic [1:0]        sel;
    logic [ADDR_W-1:0] room, big_result;

    always_comb begin
        is_malloc  = req_valid && (req_op == OP_MALLOC);
        is_free    = req_valid && (req_op == OP_FREE);
        room       = s_q.hp - FLOOR_A;
        big_result = s_q.hp - req_size;

        // best fit: smallest class with room wins
        found = 1'b0;
        sel   = '0;
        for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
            if (fits[c] && has_free[c]) begin
                found = 1'b1;
                sel   = 2'(c);
            end
        end

        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.rsp_addr  = '0;
        s_d.rsp_err   = 1'b0;
        take          = '0;
        rel           = '0;

        if (is_malloc) begin
            if (req_size > BIG_A) begin
                if (!s_q.big_busy && (req_size <= room)) begin
                    s_d.big_busy = 1'b1;
                    s_d.hp_saved = s_q.hp;
                    s_d.hp       = big_result;
                    s_d.big_addr = big_result;
                    s_d.rsp_addr = big_result;
                end
            end else if (found) begin
                take[sel]    = 1'b1;
                s_d.rsp_addr = pick_addr[sel];
            end
        end else if (is_free) begin
            if (|rel_hit) begin
                rel = rel_hit;
            end else if (s_q.big_busy && (req_addr == s_q.big_addr)) begin
                s_d.big_busy = 1'b0;
                s_d.hp       = s_q.hp_saved;
            end else begin
                s_d.rsp_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.hp       <= HP_RESET;
            s_q.hp_saved <= HP_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_addr  = s_q.rsp_addr;
    assign rsp_err   = s_q.rsp_err;

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_extra_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_free_null_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_FREE) |=> rsp_addr == '0);

    assert_malloc_noerr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_MALLOC) |=> !rsp_err);

    assert_single_big_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_MALLOC && req_size > BIG_A && s_q.big_busy)
        |=> rsp_addr == '0);

    assert_hp_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hp >= FLOOR_A);

    assert_hp_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.big_busy) |-> s_q.hp == HP_RESET);

endmodule

// File: tb/sim_seg_heap_alloc.sv
`timescale 1ns/1ps
module sim_seg_heap_alloc;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic          rsp_err;

    int errors = 0;
    int checks = 0;

    logic [AW-1:0] exp_addr_q [$];
    logic          exp_err_q  [$];
    string         tag_q      [$];

    always #2 clk = ~clk;

    seg_heap_alloc #(
        .ADDR_W(AW), .SMALL_SEGS(2), .MID_SEGS(2), .BIG_SEGS(1),
        .HEAP_TOP(8192), .HEAP_FLOOR(2048)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one request, expectation into the scoreboard
    task automatic req(input logic op, input int size, input int addr,
                       input int exp_a, input logic exp_e, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_size  = AW'(size);
        req_addr  = AW'(addr);
        exp_addr_q.push_back(AW'(exp_a));
        exp_err_q.push_back(exp_e);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", 1, 0);
            end else begin
                logic [AW-1:0] ea;
                logic          ee;
                string         t;
                ea = exp_addr_q.pop_front();
                ee = exp_err_q.pop_front();
                t  = tag_q.pop_front();
                check(rsp_addr == ea, {t, " addr"}, int'(rsp_addr), int'(ea));
                check(rsp_err == ee, {t, " err"}, int'(rsp_err), int'(ee));
            end
        end
    end

    initial begin
        #(200000 * 4);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle after reset", int'(rsp_valid), 0);

        // small 7088,7096  mid 7104,7136  big 7168  hp 7088
        req(0, 8,    0, 7088, 0, "R1 R2 first small");
        req(0, 1,    0, 7096, 0, "R2 second small");
        req(0, 5,    0, 7104, 0, "R4 small full -> mid");
        req(0, 20,   0, 7136, 0, "R3 mid");
        req(0, 30,   0, 7168, 0, "R4 mid full -> big");
        req(0, 100,  0, 0,    0, "R5 all full");
        req(1, 0, 7000, 0,    1, "R11 outside heap");
        req(1, 0, 7097, 0,    1, "R11 misaligned");
        req(0, 1,    0, 0,    0, "R11 state unchanged");
        req(1, 0, 7096, 0,    0, "R9 free small");
        req(1, 0, 7096, 0,    1, "R11 double free");
        req(0, 8,    0, 7096, 0, "R9 reuse small");
        req(0, 8,    0, 0,    0, "R5 full again");
        req(1, 0, 7136, 0,    0, "R9 free mid");
        req(0, 32,   0, 7136, 0, "R3 boundary 32");
        req(1, 0, 7168, 0,    0, "R9 free big");
        req(0, 33,   0, 7168, 0, "R3 boundary 33");
        req(0, 1025, 0, 6063, 0, "R6 oversize");
        req(0, 1500, 0, 0,    0, "R7 second oversize");
        req(1, 0, 6063, 0,    0, "R10 free oversize");
        req(0, 3000, 0, 4088, 0, "R10 pointer restored");
        req(1, 0, 4088, 0,    0, "R10 free again");
        req(0, 5041, 0, 0,    0, "R8 below floor");
        req(0, 5040, 0, 2048, 0, "R8 at floor");
        req(1, 0, 2048, 0,    0, "R10 free at floor");
        req(1, 0, 2048, 0,    1, "R11 oversize double free");

        repeat (3) @(negedge clk);
        check(exp_addr_q.size() == 0, "R12 all responses seen",
              exp_addr_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule